// File: doc/BRIEF.md
# Dual-Issue Bundle Conflict Checker

This block inspects every two-slot instruction bundle of a predicated dual-issue pipeline at the stage where operands are read. It decides whether the bundle is illegal because both of its slots are active and they compete for the same resource. Each slot supplies a guarding predicate index with an invert bit, a destination register with its write flag, and an operation class. A mode input turns on the extra pairing checks that a permissive dual-issue pipeline needs.

The block owns a small predicate register file. Predicate results from the bundle ahead, which resolve in the same cycle as the check, arrive on two write ports. They are bypassed straight into the check so that a predicate cleared just before the bundle disables its slot. The verdict is registered. One cycle after the bundle it appears as a single-cycle illegal strobe together with a 2-bit category code.

Top module: `bundle_hazard_check`

## Requirements
- R1: While reset is asserted and right after it, `illegal` is 0 and `errCode` is 0.
- R2: A bundle is flagged only when the guarding predicates of both slots evaluate true. If either slot is disabled, the bundle is legal, even with identical destinations.
- R3: If both slots are enabled, both have their write flag set, and both name the same destination register other than register 0, the bundle is flagged with code 1 (register write).
- R4: Register 0 is exempt. Two enabled writes to register 0 never produce code 1.
- R5: The register-write check has priority. A bundle that meets R3 reports code 1 even when it also forms a memory or multiply pair in permissive mode.
- R6: With `permissive` high, two enabled slots that both carry a memory class form a memory conflict, code 2. This covers load+load, store+store and load+store in either slot order. The class encoding is 0 other, 1 load, 2 store, 3 multiply.
- R7: With `permissive` high, two enabled slots that both carry class 3 (multiply) form a multiply conflict, code 3.
- R8: With `permissive` low, only the register-write check is active. Memory and multiply pairings give code 0.
- R9: Predicate index 0 always reads true and ignores writes. A slot's invert bit complements the predicate value it reads.
- R10: Predicate writes presented in a cycle are already used by the bundle checked in that cycle, and they are kept for later bundles. When both write ports target the same index, port 1 wins.
- R11: `illegal` and `errCode` are registered and refer to the bundle presented one cycle earlier. `illegal` is high only for a cycle that follows a cycle with `inValid` high, and `errCode` is 0 whenever `illegal` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | A bundle is presented this cycle |
| permissive | input | 1 | Enables the memory and multiply pairing checks |
| predIdx0 | input | PIDX_W | Slot 0 guarding predicate index |
| predNeg0 | input | 1 | Slot 0 predicate invert |
| dstReg0 | input | REG_W | Slot 0 destination register |
| wrEn0 | input | 1 | Slot 0 writes its destination |
| opClass0 | input | 2 | Slot 0 operation class |
| predIdx1 | input | PIDX_W | Slot 1 guarding predicate index |
| predNeg1 | input | 1 | Slot 1 predicate invert |
| dstReg1 | input | REG_W | Slot 1 destination register |
| wrEn1 | input | 1 | Slot 1 writes its destination |
| opClass1 | input | 2 | Slot 1 operation class |
| predWrEn0 | input | 1 | Predicate write port 0 enable |
| predWrIdx0 | input | PIDX_W | Predicate write port 0 index |
| predWrVal0 | input | 1 | Predicate write port 0 value |
| predWrEn1 | input | 1 | Predicate write port 1 enable |
| predWrIdx1 | input | PIDX_W | Predicate write port 1 index |
| predWrVal1 | input | 1 | Predicate write port 1 value |
| illegal | output | 1 | The previous cycle's bundle is illegal |
| errCode | output | 2 | 0 none, 1 register write, 2 memory, 3 multiply |

## Verification
A bundle's verdict appears on `illegal` and `errCode` one rising edge after the bundle is driven. The bench drives on the falling edge, waits through the next rising edge and compares at the falling edge after it. A predicate write counts with zero delay for the bundle driven beside it. The bench's reference therefore reads its predicate model through the same-cycle writes and updates the model only after the edge. Sweeps step one bundle per cycle, so every comparison matches exactly one bundle.

// File: rtl/bundle_hazard_pkg.sv
package bundle_hazard_pkg;

  typedef enum logic [1:0] {
    OP_OTHER = 2'd0,
    OP_LOAD  = 2'd1,
    OP_STORE = 2'd2,
    OP_MUL   = 2'd3
  } opClass_e;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_REGWR = 2'd1,
    ERR_MEM   = 2'd2,
    ERR_MUL   = 2'd3
  } errCode_e;

  // strobes from the datapath to the control
  typedef struct packed {
    logic check;     // bundle present
    logic bothOn;    // both guarding predicates true
    logic dstClash;  // same non-zero destination, both writing
    logic memPair;   // both slots are memory operations
    logic mulPair;   // both slots are multiplies
  } hazardStrobes_t;

endpackage

// File: rtl/bundle_hazard_dp.sv
module bundle_hazard_dp
  import bundle_hazard_pkg::*;
#(
  parameter int NUM_PRED = 8,
  parameter int NUM_REG  = 32,
  localparam int PIDX_W  = $clog2(NUM_PRED),
  localparam int REG_W   = $clog2(NUM_REG)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [PIDX_W-1:0] predIdx0,
  input  logic              predNeg0,
  input  logic [REG_W-1:0]  dstReg0,
  input  logic              wrEn0,
  input  logic [1:0]        opClass0,
  input  logic [PIDX_W-1:0] predIdx1,
  input  logic              predNeg1,
  input  logic [REG_W-1:0]  dstReg1,
  input  logic              wrEn1,
  input  logic [1:0]        opClass1,
  input  logic              predWrEn0,
  input  logic [PIDX_W-1:0] predWrIdx0,
  input  logic              predWrVal0,
  input  logic              predWrEn1,
  input  logic [PIDX_W-1:0] predWrIdx1,
  input  logic              predWrVal1,
  output hazardStrobes_t    strobes
);

  // bypassed predicate view: entry 0 is hard-wired true
  logic [NUM_PRED-1:0] predView;
  assign predView[0] = 1'b1;

  genvar gi;
  generate
    for (gi = 1; gi < NUM_PRED; gi++) begin : gPred
      logic predQ;
      logic predNext;
      always_comb begin
        predNext = predQ;
        if (predWrEn0 && predWrIdx0 == PIDX_W'(gi)) predNext = predWrVal0;
        if (predWrEn1 && predWrIdx1 == PIDX_W'(gi)) predNext = predWrVal1;
      end
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) predQ <= 1'b0;
        else       predQ <= predNext;
      end
      assign predView[gi] = predNext;
    end
  endgenerate

  logic slotOn0, slotOn1;
  assign slotOn0 = predView[predIdx0] ^ predNeg0;
  assign slotOn1 = predView[predIdx1] ^ predNeg1;

  opClass_e cls0, cls1;
  assign cls0 = opClass_e'(opClass0);
  assign cls1 = opClass_e'(opClass1);

  logic isMem0, isMem1;
  assign isMem0 = (cls0 == OP_LOAD) || (cls0 == OP_STORE);
  assign isMem1 = (cls1 == OP_LOAD) || (cls1 == OP_STORE);

  always_comb begin
    strobes.check    = inValid;
    strobes.bothOn   = slotOn0 && slotOn1;
    strobes.dstClash = wrEn0 && wrEn1 && (dstReg0 == dstReg1) && (dstReg0 != '0);
    strobes.memPair  = isMem0 && isMem1;
    strobes.mulPair  = (cls0 == OP_MUL) && (cls1 == OP_MUL);
  end

endmodule

// File: rtl/bundle_hazard_ctl.sv
module bundle_hazard_ctl
  import bundle_hazard_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           permissive,
  input  hazardStrobes_t strobes,
  output logic           illegal,
  output logic [1:0]     errCode
);

  errCode_e codeNext;
  errCode_e codeQ;

  always_comb begin
    codeNext = ERR_NONE;
    if (strobes.check && strobes.bothOn) begin
      if (strobes.dstClash)                   codeNext = ERR_REGWR;
      else if (permissive && strobes.memPair) codeNext = ERR_MEM;
      else if (permissive && strobes.mulPair) codeNext = ERR_MUL;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeQ   <= ERR_NONE;
      illegal <= 1'b0;
    end else begin
      codeQ   <= codeNext;
      illegal <= (codeNext != ERR_NONE);
    end
  end

  assign errCode = codeQ;

endmodule

// File: rtl/bundle_hazard_check.sv
module bundle_hazard_check
  import bundle_hazard_pkg::*;
#(
  parameter int NUM_PRED = 8,
  parameter int NUM_REG  = 32,
  localparam int PIDX_W  = $clog2(NUM_PRED),
  localparam int REG_W   = $clog2(NUM_REG)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              permissive,
  input  logic [PIDX_W-1:0] predIdx0,
  input  logic              predNeg0,
  input  logic [REG_W-1:0]  dstReg0,
  input  logic              wrEn0,
  input  logic [1:0]        opClass0,
  input  logic [PIDX_W-1:0] predIdx1,
  input  logic              predNeg1,
  input  logic [REG_W-1:0]  dstReg1,
  input  logic              wrEn1,
  input  logic [1:0]        opClass1,
  input  logic              predWrEn0,
  input  logic [PIDX_W-1:0] predWrIdx0,
  input  logic              predWrVal0,
  input  logic              predWrEn1,
  input  logic [PIDX_W-1:0] predWrIdx1,
  input  logic              predWrVal1,
  output logic              illegal,
  output logic [1:0]        errCode
);

  hazardStrobes_t strobes;

  bundle_hazard_dp #(.NUM_PRED(NUM_PRED), .NUM_REG(NUM_REG)) uDp (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .predIdx0(predIdx0), .predNeg0(predNeg0), .dstReg0(dstReg0),
    .wrEn0(wrEn0), .opClass0(opClass0),
    .predIdx1(predIdx1), .predNeg1(predNeg1), .dstReg1(dstReg1),
    .wrEn1(wrEn1), .opClass1(opClass1),
    .predWrEn0(predWrEn0), .predWrIdx0(predWrIdx0), .predWrVal0(predWrVal0),
    .predWrEn1(predWrEn1), .predWrIdx1(predWrIdx1), .predWrVal1(predWrVal1),
    .strobes(strobes)
  );

  bundle_hazard_ctl uCtl (
    .clk(clk), .rstN(rstN), .permissive(permissive),
    .strobes(strobes), .illegal(illegal), .errCode(errCode)
  );

endmodule

// File: rtl/bundle_hazard_chk.sv
module bundle_hazard_chk #(
  parameter int NUM_PRED = 8,
  parameter int NUM_REG  = 32,
  localparam int PIDX_W  = $clog2(NUM_PRED),
  localparam int REG_W   = $clog2(NUM_REG)
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              permissive,
  input logic [PIDX_W-1:0] predIdx0,
  input logic              predNeg0,
  input logic [REG_W-1:0]  dstReg0,
  input logic              wrEn0,
  input logic [1:0]        opClass0,
  input logic [PIDX_W-1:0] predIdx1,
  input logic              predNeg1,
  input logic [REG_W-1:0]  dstReg1,
  input logic              wrEn1,
  input logic [1:0]        opClass1,
  input logic              predWrEn0,
  input logic [PIDX_W-1:0] predWrIdx0,
  input logic              predWrVal0,
  input logic              predWrEn1,
  input logic [PIDX_W-1:0] predWrIdx1,
  input logic              predWrVal1,
  input logic              illegal,
  input logic [1:0]        errCode
);

  // high once a full cycle out of reset has passed, so $past sees live inputs
  logic pastOk;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  assert_flag_has_code_R11: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> errCode != 2'd0);

  assert_code_clear_R11: assert property (@(posedge clk) disable iff (!rstN)
    !illegal |-> errCode == 2'd0);

  assert_idle_silent_R11: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $past(!inValid)) |-> !illegal);

  assert_strict_mode_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $past(!permissive) && illegal) |-> errCode == 2'd1);

  assert_zero_exempt_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $past(inValid && !permissive && wrEn0 && wrEn1 &&
                     dstReg0 == '0 && dstReg1 == '0)) |-> !illegal);

  assert_dest_clash_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $past(inValid && predIdx0 == '0 && !predNeg0 &&
                     predIdx1 == '0 && !predNeg1 && wrEn0 && wrEn1 &&
                     dstReg0 == dstReg1 && dstReg0 != '0))
      |-> (illegal && errCode == 2'd1));

endmodule

bind bundle_hazard_check bundle_hazard_chk #(.NUM_PRED(NUM_PRED), .NUM_REG(NUM_REG)) uChk (.*);

// File: tb/tb_bundle_hazard_check.sv
`timescale 1ns/1ps
module tb_bundle_hazard_check;

  localparam int NP = 4;
  localparam int NR = 4;
  localparam int PW = $clog2(NP);
  localparam int RW = $clog2(NR);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 0, permissive = 0;
  logic [PW-1:0] predIdx0 = 0, predIdx1 = 0, predWrIdx0 = 0, predWrIdx1 = 0;
  logic predNeg0 = 0, predNeg1 = 0, wrEn0 = 0, wrEn1 = 0;
  logic [RW-1:0] dstReg0 = 0, dstReg1 = 0;
  logic [1:0] opClass0 = 0, opClass1 = 0;
  logic predWrEn0 = 0, predWrVal0 = 0, predWrEn1 = 0, predWrVal1 = 0;
  logic illegal;
  logic [1:0] errCode;

  int nChecks = 0;
  int nFails = 0;
  bit modelPred [NP];

  always #2 clk = ~clk;

  bundle_hazard_check #(.NUM_PRED(NP), .NUM_REG(NR)) dut (.*);

  function automatic bit predOf(logic [PW-1:0] idx);
    bit v;
    if (idx == 0) return 1'b1;
    v = modelPred[idx];
    if (predWrEn0 && predWrIdx0 == idx) v = predWrVal0;
    if (predWrEn1 && predWrIdx1 == idx) v = predWrVal1;
    return v;
  endfunction

  function automatic logic [1:0] expectCode();
    bit on0, on1, mem0, mem1;
    if (!inValid) return 2'd0;
    on0 = predOf(predIdx0) ^ predNeg0;
    on1 = predOf(predIdx1) ^ predNeg1;
    if (!(on0 && on1)) return 2'd0;
    if (wrEn0 && wrEn1 && dstReg0 == dstReg1 && dstReg0 != 0) return 2'd1;
    if (!permissive) return 2'd0;
    mem0 = (opClass0 == 2'd1) || (opClass0 == 2'd2);
    mem1 = (opClass1 == 2'd1) || (opClass1 == 2'd2);
    if (mem0 && mem1) return 2'd2;
    if (opClass0 == 2'd3 && opClass1 == 2'd3) return 2'd3;
    return 2'd0;
  endfunction

  task automatic compare(string tag, logic [1:0] exp);
    nChecks++;
    if (illegal !== (exp != 2'd0) || errCode !== exp) begin
      nFails++;
      $display("FAIL %s: illegal=%0b errCode=%0d expected illegal=%0b errCode=%0d",
               tag, illegal, errCode, exp != 2'd0, exp);
    end
  endtask

  // drive already set at a falling edge; verdict due one rising edge later
  task automatic step(string tag);
    logic [1:0] exp;
    exp = expectCode();
    @(posedge clk);
    if (predWrEn0 && predWrIdx0 != 0) modelPred[predWrIdx0] = predWrVal0;
    if (predWrEn1 && predWrIdx1 != 0) modelPred[predWrIdx1] = predWrVal1;
    @(negedge clk);
    compare(tag, exp);
  endtask

  task automatic noWrites();
    predWrEn0 = 0; predWrEn1 = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NP; i++) modelPred[i] = 1'b0;
    repeat (3) @(negedge clk);
    compare("R1 in reset", 2'd0);
    rstN = 1'b1;
    @(negedge clk);
    compare("R1 after reset", 2'd0);

    // sweep classes, destinations, write flags and mode with p0 guards (R3 R4 R5 R6 R7 R8)
    inValid = 1;
    for (int pm = 0; pm < 2; pm++)
      for (int c0 = 0; c0 < 4; c0++)
        for (int c1 = 0; c1 < 4; c1++)
          for (int d0 = 0; d0 < NR; d0++)
            for (int d1 = 0; d1 < NR; d1++)
              for (int w = 0; w < 4; w++) begin
                string tag;
                logic [1:0] e;
                permissive = pm[0];
                opClass0 = c0[1:0]; opClass1 = c1[1:0];
                dstReg0 = d0[RW-1:0]; dstReg1 = d1[RW-1:0];
                wrEn0 = w[0]; wrEn1 = w[1];
                e = expectCode();
                if (e == 2'd1 && pm == 1 && ((c0 != 0 && c1 != 0))) tag = "R5 priority";
                else if (e == 2'd1) tag = "R3 dest clash";
                else if (e == 2'd2) tag = "R6 memory pair";
                else if (e == 2'd3) tag = "R7 multiply pair";
                else if (d0 == 0 && d1 == 0 && w == 3) tag = "R4 zero exempt";
                else tag = "R8 strict/no clash";
                step(tag);
              end

    // load predicates: p1=1, p2=0, p3=1
    inValid = 0;
    predWrEn0 = 1; predWrIdx0 = 1; predWrVal0 = 1;
    predWrEn1 = 1; predWrIdx1 = 3; predWrVal1 = 1;
    step("R11 idle with writes");
    noWrites();

    // predicate sweep on a clashing, memory-pair bundle (R2 R9)
    inValid = 1; permissive = 1;
    opClass0 = 2'd1; opClass1 = 2'd2;
    wrEn0 = 1; wrEn1 = 1; dstReg0 = 1; dstReg1 = 1;
    for (int i0 = 0; i0 < NP; i0++)
      for (int n0 = 0; n0 < 2; n0++)
        for (int i1 = 0; i1 < NP; i1++)
          for (int n1 = 0; n1 < 2; n1++) begin
            predIdx0 = i0[PW-1:0]; predNeg0 = n0[0];
            predIdx1 = i1[PW-1:0]; predNeg1 = n1[0];
            if (i0 == 0 || i1 == 0 || n0 == 1 || n1 == 1) step("R9 predicate eval");
            else step("R2 enable gating");
          end

    // writes to p0 are ignored (R9)
    predIdx0 = 0; predNeg0 = 0; predIdx1 = 0; predNeg1 = 0;
    predWrEn0 = 1; predWrIdx0 = 0; predWrVal0 = 0;
    step("R9 p0 write same cycle");
    noWrites();
    step("R9 p0 after write");

    // forwarding (R10): p1 is 1, clear it alongside the bundle that uses it
    predIdx0 = 1;
    predWrEn0 = 1; predWrIdx0 = 1; predWrVal0 = 0;
    step("R10 bypass clear");
    noWrites();
    step("R10 cleared value kept");
    // both ports hit p2: port 1 wins
    predIdx0 = 2;
    predWrEn0 = 1; predWrIdx0 = 2; predWrVal0 = 1;
    predWrEn1 = 1; predWrIdx1 = 2; predWrVal1 = 0;
    step("R10 port1 wins low");
    predWrVal0 = 0; predWrVal1 = 1;
    step("R10 port1 wins high");
    noWrites();
    step("R10 kept high");

    // invalid bundle with a clash, then back-to-back (R11)
    inValid = 0;
    step("R11 invalid ignored");
    inValid = 1;
    step("R11 valid flagged");
    inValid = 0;
    step("R11 single cycle");

    // mixed traffic with writes (R10 R2 R6 R7)
    inValid = 1;
    for (int k = 0; k < 600; k++) begin
      logic [31:0] r;
      r = $urandom;
      permissive = r[0];
      predIdx0 = r[2:1]; predNeg0 = r[3]; predIdx1 = r[5:4]; predNeg1 = r[6];
      dstReg0 = r[8:7]; dstReg1 = r[10:9]; wrEn0 = r[11]; wrEn1 = r[12];
      opClass0 = r[14:13]; opClass1 = r[16:15];
      predWrEn0 = r[17]; predWrIdx0 = r[19:18]; predWrVal0 = r[20];
      predWrEn1 = r[21]; predWrIdx1 = r[23:22]; predWrVal1 = r[24];
      inValid = (r[27:25] != 0);
      step("R10 mixed traffic");
    end
    noWrites();
    inValid = 0;
    step("R11 drain");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule